// File: doc/BRIEF.md
# Shadowed-Time Real-Time Clock

This block is a real-time clock peripheral on a simple 32-bit register bus. It keeps a 32-bit seconds count and a sub-second (millisecond) count. Both advance from a slow tick enable, nominally 32 kHz, through a fractional accumulator. Software never sees the counters directly. It sees a bus-side copy that is refreshed once every few ticks, and a busy flag is raised while that refresh is in progress. Reading the sub-second register also captures the bus-side seconds into a shadow register, so the two halves of a time reading always belong together.

Two seconds alarms and one sub-second alarm raise flags in a write-1-to-clear status register. An enable mask selects which flags drive the active-high, level-sensitive interrupt output. Two countdown flag positions exist only as storable enables and never-set flags. The whole block runs on one clock, and the slow tick arrives as a one-cycle enable.

Top module: `rtc_shadow_top`

## Requirements
- R1: After synchronous reset, all readable registers are 0, the busy bit is 0 and the interrupt output is low.
- R2: Each tick adds SUB_PER_SEC to an accumulator. When the sum reaches TICK_HZ, TICK_HZ is subtracted and the sub-second count steps. The sub-second count runs 0 to SUB_PER_SEC-1. Its wrap to 0 increments seconds, and seconds roll over from 0xFFFFFFFF to 0.
- R3: The bus-visible seconds (offset 0x00) and sub-second (offset 0x04) values change only through a copy or a seconds write. On every COPY_TICKS-th tick since reset, bit 0 of the busy register (offset 0x0C) reads 1 for BUSY_LEN cycles starting the cycle after that tick. The copy takes the live values in the last of those cycles.
- R4: A read of offset 0x04 loads the shadow seconds register (offset 0x08) with the bus-visible seconds. The shadow holds that value until the next such read.
- R5: A write to offset 0x00 while busy reads 0 is taken by the live counter and by the bus view, and clears the sub-second count and the accumulator. A write while busy reads 1 is dropped.
- R6: Seconds alarm A (offset 0x10) and alarm B (offset 0x14) set status bit 0 and bit 1 respectively on the tick where counting makes seconds equal to the alarm value. An alarm value of 0 never fires, and a seconds write never fires an alarm.
- R7: The sub-second alarm (offset 0x18) sets status bit 2 on the tick where the sub-second count steps to its value.
- R8: In the status register (offset 0x20), writing 1 to a bit clears it and writing 0 leaves it unchanged. A same-cycle set wins over the clear, and flags are set whatever the mask holds.
- R9: The interrupt output is high exactly while some status bit and the same bit of the mask register (offset 0x1C, bits 4:0) are both 1.
- R10: Mask bits 3 and 4 (seconds countdown, sub-second countdown) can be written and read back. Hardware never sets status bits 3 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle slow tick enable (nominally 32 kHz) |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_sel is high with bus_wr low; 0 otherwise |
| irq | output | 1 | Level-high interrupt |

## Verification
The bench builds the block with TICK_HZ=8, SUB_PER_SEC=4, COPY_TICKS=4 and BUSY_LEN=3. With these values a sub-second step comes every second tick, a full second every eight ticks, and a copy every fourth tick. That brings seconds alarms, sub-second alarm matches, seconds rollover from 0xFFFFFFFF, a stale bus view between copies and a write into an open busy window within a few dozen ticks. Because the bench drives the tick itself, every expected value follows from counting ticks.

// File: rtl/rtc_shadow_pkg.sv
package rtc_shadow_pkg;

    localparam int DATA_W        = 32;
    localparam int ADDR_W        = 8;
    localparam int SUB_W         = 16;
    localparam int NUM_IRQ       = 5;
    localparam int NUM_SEC_ALARM = 2;

    // Flag positions shared by the mask and status registers
    localparam int IRQ_SEC_A   = 0;
    localparam int IRQ_SEC_B   = 1;
    localparam int IRQ_SUB     = 2;
    localparam int IRQ_SEC_CDN = 3;
    localparam int IRQ_SUB_CDN = 4;

    // Register byte offsets
    localparam logic [ADDR_W-1:0] OFF_SEC      = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_SUB      = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_SHADOW   = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_BUSY     = 8'h0C;
    localparam logic [ADDR_W-1:0] OFF_ALM_SEC0 = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_ALM_SUB  = 8'h18;
    localparam logic [ADDR_W-1:0] OFF_IRQ_EN   = 8'h1C;
    localparam logic [ADDR_W-1:0] OFF_IRQ_FLAG = 8'h20;

    typedef struct packed {
        logic [DATA_W-1:0] sec;
        logic [SUB_W-1:0]  sub;
    } rtc_time_t;

    typedef struct packed {
        logic              sel;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    // Offset of the seconds alarm with the given index
    function automatic logic [ADDR_W-1:0] sec_alarm_off(input int idx);
        return OFF_ALM_SEC0 + ADDR_W'(idx * 4);
    endfunction

    function automatic logic is_write(input bus_req_t req, input logic [ADDR_W-1:0] off);
        return req.sel && req.wr && (req.addr == off);
    endfunction

    function automatic logic is_read(input bus_req_t req, input logic [ADDR_W-1:0] off);
        return req.sel && !req.wr && (req.addr == off);
    endfunction

endpackage

// File: rtl/rtc_timebase.sv
module rtc_timebase
    import rtc_shadow_pkg::*;
#(
    parameter int TICK_HZ     = 32768,
    parameter int SUB_PER_SEC = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              load_en,
    input  logic [DATA_W-1:0] load_sec,
    output rtc_time_t         live,
    output rtc_time_t         live_next,
    output logic              sub_step,
    output logic              sec_step
);

    localparam int ACC_W = $clog2(TICK_HZ + SUB_PER_SEC + 1);
    localparam logic [ACC_W-1:0] ACC_ADD = ACC_W'(SUB_PER_SEC);
    localparam logic [ACC_W-1:0] ACC_TOP = ACC_W'(TICK_HZ);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(SUB_PER_SEC - 1);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_sum;
    logic [ACC_W-1:0] acc_nx;
    logic             step_raw;
    logic             sub_wrap;

    always_comb begin
        acc_sum  = acc_q + ACC_ADD;
        step_raw = tick && (acc_sum >= ACC_TOP);
        acc_nx   = step_raw ? (acc_sum - ACC_TOP) : acc_sum;
        sub_wrap = (live.sub == SUB_LAST);

        live_next = live;
        if (step_raw) begin
            if (sub_wrap) begin
                live_next.sub = '0;
                live_next.sec = live.sec + 1'b1;
            end else begin
                live_next.sub = live.sub + 1'b1;
            end
        end

        // A load overrides counting, so no step is reported then
        sub_step = step_raw && !load_en;
        sec_step = step_raw && sub_wrap && !load_en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            live  <= '0;
        end else if (load_en) begin
            acc_q    <= '0;
            live.sec <= load_sec;
            live.sub <= '0;
        end else if (tick) begin
            acc_q <= acc_nx;
            live  <= live_next;
        end
    end

endmodule

// File: rtl/rtc_mirror.sv
module rtc_mirror
    import rtc_shadow_pkg::*;
#(
    parameter int COPY_TICKS = 8,
    parameter int BUSY_LEN   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  rtc_time_t         live,
    input  logic              load_en,
    input  logic [DATA_W-1:0] load_sec,
    input  logic              snap,
    output rtc_time_t         view,
    output logic [DATA_W-1:0] shadow_sec,
    output logic              busy
);

    localparam int CW = (COPY_TICKS > 1) ? $clog2(COPY_TICKS) : 1;
    localparam int BW = $clog2(BUSY_LEN + 1);
    localparam logic [CW-1:0] COPY_LAST = CW'(COPY_TICKS - 1);
    localparam logic [BW-1:0] BUSY_INIT = BW'(BUSY_LEN);

    logic [CW-1:0] copy_cnt;
    logic [BW-1:0] busy_cnt;
    logic          copy_start;
    logic          copy_take;

    assign copy_start = tick && (copy_cnt == COPY_LAST);
    assign copy_take  = (busy_cnt == BW'(1));
    assign busy       = (busy_cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            copy_cnt <= '0;
        end else if (tick) begin
            copy_cnt <= (copy_cnt == COPY_LAST) ? '0 : copy_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_cnt <= '0;
        end else if (copy_start) begin
            busy_cnt <= BUSY_INIT;
        end else if (busy) begin
            busy_cnt <= busy_cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            view <= '0;
        end else if (load_en) begin
            view.sec <= load_sec;
            view.sub <= '0;
        end else if (copy_take) begin
            view <= live;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_sec <= '0;
        end else if (snap) begin
            shadow_sec <= view.sec;
        end
    end

endmodule

// File: rtl/rtc_irq_unit.sv
module rtc_irq_unit
    import rtc_shadow_pkg::*;
(
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  sec_step,
    input  logic                                  sub_step,
    input  rtc_time_t                             live_next,
    input  logic [NUM_SEC_ALARM-1:0]              alm_sec_wr,
    input  logic                                  alm_sub_wr,
    input  logic                                  en_wr,
    input  logic                                  flag_wr,
    input  logic [DATA_W-1:0]                     wdata,
    output logic [NUM_SEC_ALARM-1:0][DATA_W-1:0]  alm_sec,
    output logic [SUB_W-1:0]                      alm_sub,
    output logic [NUM_IRQ-1:0]                    en,
    output logic [NUM_IRQ-1:0]                    flag,
    output logic [NUM_IRQ-1:0]                    set_vec,
    output logic                                  irq
);

    logic [NUM_IRQ-1:0] clr_vec;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_SEC_ALARM; gi++) begin : g_sec_alarm
            always_ff @(posedge clk) begin
                if (rst) begin
                    alm_sec[gi] <= '0;
                end else if (alm_sec_wr[gi]) begin
                    alm_sec[gi] <= wdata;
                end
            end
            // Zero means the alarm is switched off
            assign set_vec[IRQ_SEC_A + gi] = sec_step && (alm_sec[gi] != '0)
                                           && (live_next.sec == alm_sec[gi]);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            alm_sub <= '0;
        end else if (alm_sub_wr) begin
            alm_sub <= wdata[SUB_W-1:0];
        end
    end

    assign set_vec[IRQ_SUB]     = sub_step && (live_next.sub == alm_sub);
    assign set_vec[IRQ_SEC_CDN] = 1'b0;
    assign set_vec[IRQ_SUB_CDN] = 1'b0;

    assign clr_vec = flag_wr ? wdata[NUM_IRQ-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            en <= '0;
        end else if (en_wr) begin
            en <= wdata[NUM_IRQ-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= '0;
        end else begin
            flag <= (flag & ~clr_vec) | set_vec;
        end
    end

    assign irq = |(flag & en);

endmodule

// File: rtl/rtc_shadow_top.sv
module rtc_shadow_top
    import rtc_shadow_pkg::*;
#(
    parameter int TICK_HZ     = 32768,
    parameter int SUB_PER_SEC = 1000,
    parameter int COPY_TICKS  = 8,
    parameter int BUSY_LEN    = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq
);

    bus_req_t  req;
    rtc_time_t live_t;
    rtc_time_t live_nx;
    rtc_time_t view_t;
    logic [DATA_W-1:0] shadow_q;
    logic      busy_w;
    logic      sub_step;
    logic      sec_step;
    logic      sec_wr_req;
    logic      sec_load;
    logic      sub_rd;
    logic      en_wr;
    logic      flag_wr;
    logic      alm_sub_wr;
    logic [NUM_SEC_ALARM-1:0]             alm_sec_wr;
    logic [NUM_SEC_ALARM-1:0][DATA_W-1:0] alm_sec_q;
    logic [SUB_W-1:0]   alm_sub_q;
    logic [NUM_IRQ-1:0] en_q;
    logic [NUM_IRQ-1:0] flag_q;
    logic [NUM_IRQ-1:0] set_vec;

    assign req = '{sel: bus_sel, wr: bus_wr, addr: bus_addr, wdata: bus_wdata};

    assign sec_wr_req = is_write(req, OFF_SEC);
    assign sec_load   = sec_wr_req && !busy_w;
    assign sub_rd     = is_read(req, OFF_SUB);
    assign en_wr      = is_write(req, OFF_IRQ_EN);
    assign flag_wr    = is_write(req, OFF_IRQ_FLAG);
    assign alm_sub_wr = is_write(req, OFF_ALM_SUB);

    genvar gi;
    generate
        for (gi = 0; gi < NUM_SEC_ALARM; gi++) begin : g_alm_dec
            assign alm_sec_wr[gi] = is_write(req, sec_alarm_off(gi));
        end
    endgenerate

    rtc_timebase #(
        .TICK_HZ    (TICK_HZ),
        .SUB_PER_SEC(SUB_PER_SEC)
    ) u_timebase (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .load_en  (sec_load),
        .load_sec (bus_wdata),
        .live     (live_t),
        .live_next(live_nx),
        .sub_step (sub_step),
        .sec_step (sec_step)
    );

    rtc_mirror #(
        .COPY_TICKS(COPY_TICKS),
        .BUSY_LEN  (BUSY_LEN)
    ) u_mirror (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .live      (live_t),
        .load_en   (sec_load),
        .load_sec  (bus_wdata),
        .snap      (sub_rd),
        .view      (view_t),
        .shadow_sec(shadow_q),
        .busy      (busy_w)
    );

    rtc_irq_unit u_irq (
        .clk       (clk),
        .rst       (rst),
        .sec_step  (sec_step),
        .sub_step  (sub_step),
        .live_next (live_nx),
        .alm_sec_wr(alm_sec_wr),
        .alm_sub_wr(alm_sub_wr),
        .en_wr     (en_wr),
        .flag_wr   (flag_wr),
        .wdata     (bus_wdata),
        .alm_sec   (alm_sec_q),
        .alm_sub   (alm_sub_q),
        .en        (en_q),
        .flag      (flag_q),
        .set_vec   (set_vec),
        .irq       (irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            unique case (bus_addr)
                OFF_SEC:      bus_rdata = view_t.sec;
                OFF_SUB:      bus_rdata = DATA_W'(view_t.sub);
                OFF_SHADOW:   bus_rdata = shadow_q;
                OFF_BUSY:     bus_rdata = DATA_W'(busy_w);
                OFF_ALM_SUB:  bus_rdata = DATA_W'(alm_sub_q);
                OFF_IRQ_EN:   bus_rdata = DATA_W'(en_q);
                OFF_IRQ_FLAG: bus_rdata = DATA_W'(flag_q);
                default: begin
                    for (int i = 0; i < NUM_SEC_ALARM; i++) begin
                        if (bus_addr == sec_alarm_off(i)) bus_rdata = alm_sec_q[i];
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/rtc_shadow_chk.sv
module rtc_shadow_chk
    import rtc_shadow_pkg::*;
#(
    parameter int SUB_PER_SEC = 1000
) (
    input logic               clk,
    input logic               rst,
    input logic               tick,
    input logic               sec_wr_req,
    input logic               sub_rd,
    input logic               flag_wr,
    input logic [DATA_W-1:0]  wdata,
    input logic               busy,
    input rtc_time_t          live,
    input rtc_time_t          view,
    input logic [DATA_W-1:0]  shadow_sec,
    input logic [NUM_IRQ-1:0] flag,
    input logic [NUM_IRQ-1:0] set_vec,
    input logic               irq
);

    // R2: sub-second count stays inside its range
    p_sub_range_r2: assert property (@(posedge clk) disable iff (rst)
        live.sub < SUB_W'(SUB_PER_SEC));

    // R3: bus view holds unless a copy window or a seconds load is open
    p_view_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!busy && !sec_wr_req) |=> (view == $past(view)));

    // R4: a sub-second read captures the bus-visible seconds
    p_shadow_take_r4: assert property (@(posedge clk) disable iff (rst)
        sub_rd |=> (shadow_sec == $past(view.sec)));

    // R5: a seconds write inside the busy window leaves the counter alone
    p_busy_drop_r5: assert property (@(posedge clk) disable iff (rst)
        (sec_wr_req && busy && !tick) |=> (live.sec == $past(live.sec)));

    // R8: write-1 clears a flag unless it is being set in the same cycle
    p_w1c_r8: assert property (@(posedge clk) disable iff (rst)
        (flag_wr && wdata[IRQ_SEC_A] && !set_vec[IRQ_SEC_A]) |=> !flag[IRQ_SEC_A]);

    // R9: no pending flag, no interrupt
    p_irq_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (flag == '0) |-> !irq);

    // R10: countdown flags never rise
    p_cdn_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((flag[IRQ_SUB_CDN:IRQ_SEC_CDN] & ~$past(flag[IRQ_SUB_CDN:IRQ_SEC_CDN])) == 2'b00));

endmodule

bind rtc_shadow_top rtc_shadow_chk #(
    .SUB_PER_SEC(SUB_PER_SEC)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .sec_wr_req(sec_wr_req),
    .sub_rd    (sub_rd),
    .flag_wr   (flag_wr),
    .wdata     (bus_wdata),
    .busy      (busy_w),
    .live      (live_t),
    .view      (view_t),
    .shadow_sec(shadow_q),
    .flag      (flag_q),
    .set_vec   (set_vec),
    .irq       (irq)
);

// File: tb/tb_rtc_shadow_top.sv
module tb_rtc_shadow_top;

    localparam logic [1:0] OP_RD = 2'd0, OP_WR = 2'd1, OP_TK = 2'd2, OP_IQ = 2'd3;
    localparam logic [7:0] A_SEC = 8'h00, A_SUB = 8'h04, A_SHD = 8'h08, A_BSY = 8'h0C,
                           A_AL0 = 8'h10, A_AL1 = 8'h14, A_ALS = 8'h18, A_EN = 8'h1C,
                           A_FLG = 8'h20;

    typedef struct packed {
        logic [1:0]  op;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 51;
    localparam vec_t VEC [NV] = '{
        '{OP_RD, A_SEC, 32'd0,          4'd1},  // R1
        '{OP_RD, A_BSY, 32'd0,          4'd1},  // R1
        '{OP_RD, A_FLG, 32'd0,          4'd1},  // R1
        '{OP_WR, A_SEC, 32'd100,        4'd5},  // R5
        '{OP_RD, A_SEC, 32'd100,        4'd5},  // R5
        '{OP_RD, A_SUB, 32'd0,          4'd5},  // R5
        '{OP_TK, 8'h00, 32'd2,          4'd2},  // R2
        '{OP_RD, A_SUB, 32'd0,          4'd3},  // R3 stale view
        '{OP_TK, 8'h00, 32'd2,          4'd2},
        '{OP_RD, A_SUB, 32'd2,          4'd3},  // R3 copy at tick 4
        '{OP_RD, A_SHD, 32'd100,        4'd4},  // R4
        '{OP_WR, A_AL0, 32'd101,        4'd6},  // R6
        '{OP_WR, A_EN,  32'd1,          4'd9},  // R9
        '{OP_TK, 8'h00, 32'd4,          4'd2},
        '{OP_RD, A_FLG, 32'd5,          4'd6},  // R6 alarm A plus sub alarm at 0
        '{OP_IQ, 8'h00, 32'd1,          4'd9},  // R9
        '{OP_RD, A_SHD, 32'd100,        4'd4},  // R4 not yet recaptured
        '{OP_RD, A_SUB, 32'd0,          4'd2},  // R2 wrap
        '{OP_RD, A_SHD, 32'd101,        4'd4},  // R4
        '{OP_RD, A_SEC, 32'd101,        4'd2},  // R2
        '{OP_WR, A_FLG, 32'd0,          4'd8},  // R8
        '{OP_RD, A_FLG, 32'd5,          4'd8},  // R8 zero write ignored
        '{OP_WR, A_EN,  32'd0,          4'd9},
        '{OP_IQ, 8'h00, 32'd0,          4'd9},  // R9
        '{OP_RD, A_FLG, 32'd5,          4'd8},  // R8 flags kept without mask
        '{OP_WR, A_FLG, 32'd5,          4'd8},
        '{OP_RD, A_FLG, 32'd0,          4'd8},  // R8
        '{OP_WR, A_AL1, 32'd102,        4'd6},
        '{OP_WR, A_ALS, 32'd2,          4'd7},  // R7
        '{OP_WR, A_EN,  32'd6,          4'd9},
        '{OP_TK, 8'h00, 32'd4,          4'd7},
        '{OP_RD, A_FLG, 32'd4,          4'd7},  // R7
        '{OP_IQ, 8'h00, 32'd1,          4'd9},  // R9
        '{OP_TK, 8'h00, 32'd4,          4'd6},
        '{OP_RD, A_FLG, 32'd6,          4'd6},  // R6 alarm B
        '{OP_WR, A_FLG, 32'd4,          4'd8},
        '{OP_RD, A_FLG, 32'd2,          4'd8},  // R8 partial clear
        '{OP_WR, A_EN,  32'h1F,         4'd10}, // R10
        '{OP_RD, A_EN,  32'h1F,         4'd10}, // R10
        '{OP_WR, A_FLG, 32'hFFFFFFFF,   4'd8},
        '{OP_RD, A_FLG, 32'd0,          4'd10}, // R10
        '{OP_IQ, 8'h00, 32'd0,          4'd9},  // R9
        '{OP_WR, A_AL0, 32'd0,          4'd6},
        '{OP_WR, A_SEC, 32'hFFFFFFFF,   4'd5},
        '{OP_RD, A_SEC, 32'hFFFFFFFF,   4'd5},  // R5
        '{OP_TK, 8'h00, 32'd8,          4'd2},
        '{OP_RD, A_FLG, 32'd4,          4'd6},  // R6 zero alarm silent
        '{OP_RD, A_SEC, 32'd0,          4'd2},  // R2 rollover
        '{OP_RD, A_SUB, 32'd0,          4'd2},
        '{OP_IQ, 8'h00, 32'd1,          4'd9},
        '{OP_RD, A_AL1, 32'd102,        4'd6}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    rtc_shadow_top #(
        .TICK_HZ    (8),
        .SUB_PER_SEC(4),
        .COPY_TICKS (4),
        .BUSY_LEN   (3)
    ) dut (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .irq      (irq)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic tick_once();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 irq after reset", {31'd0, irq}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            case (VEC[i].op)
                OP_RD: begin
                    bus_read(VEC[i].addr, rd);
                    check($sformatf("R%0d step %0d", VEC[i].req, i), rd, VEC[i].data);
                end
                OP_WR: bus_write(VEC[i].addr, VEC[i].data);
                OP_TK: for (int k = 0; k < int'(VEC[i].data); k++) tick_once();
                default: begin
                    @(negedge clk);
                    #1 check($sformatf("R%0d step %0d irq", VEC[i].req, i), {31'd0, irq}, VEC[i].data);
                end
            endcase
        end

        // R3 and R5: a seconds write landing inside the busy window (tick 28 copies)
        for (int k = 0; k < 3; k++) tick_once();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = A_BSY;
        #1 check("R3 busy raised after copy tick", bus_rdata, 32'd1);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = A_SEC; bus_wdata = 32'd555;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        repeat (4) @(negedge clk);
        bus_read(A_SEC, rd);
        check("R5 write during busy dropped", rd, 32'd0);
        bus_read(A_SUB, rd);
        check("R3 copy carries sub-second", rd, 32'd2);
        bus_read(A_BSY, rd);
        check("R3 busy clears", rd, 32'd0);
        bus_write(A_SEC, 32'd555);
        bus_read(A_SEC, rd);
        check("R5 idle write taken", rd, 32'd555);
        bus_read(A_SUB, rd);
        check("R5 write clears sub-second", rd, 32'd0);

        // R1: reset returns everything to zero
        @(negedge clk) rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        bus_read(A_SEC, rd);
        check("R1 seconds after reset", rd, 32'd0);
        bus_read(A_FLG, rd);
        check("R1 flags after reset", rd, 32'd0);
        bus_read(A_EN, rd);
        check("R1 mask after reset", rd, 32'd0);
        @(negedge clk);
        #1 check("R1 irq low after reset", {31'd0, irq}, 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule